// File: doc/BRIEF.md
# Transmit Deferral Controller

This block decides when an Ethernet transmitter may begin its next frame. It merges two hold-off sources into a single permission flag. The first is retry backoff: each collision raises an attempt count and starts a wait of a whole number of slot times. In normal operation that number is random. The second is flow-control pause: an accepted pause request loads a quanta value, which then counts down to zero. The flag is high only while neither source is holding the transmitter back.

The MAC drives the block with single-cycle strobes. These mark a frame start, a successful frame end, a collision, and a received pause request together with its 16-bit quanta. A bit-time tick paces the slot and quanta timing. A receive clock enable gives the fast decrement used in test mode. A test-mode input shortens both timers so that long scenarios run in few cycles, such as running out of retries. The test-mode bit must be low in service. When too many attempts collide, the block reports it with a one-cycle flag.

Top module: `txdefer_ctrl`

## Requirements
- R1: After reset, tx_allowed is 1 and excess_retry is 0.
- R2: With pause_en high, a pause_rx strobe carrying a nonzero quanta q drives tx_allowed low from the next cycle. In normal mode, tx_allowed returns high once q*QUANTUM_BITS bit_tick pulses have been counted.
- R3: With test_mode high, an accepted pause counts down by one on every cycle with rx_ce high, and bit_tick is ignored. tx_allowed returns high after exactly q such cycles.
- R4: An accepted pause that arrives while a pause is already running restarts the countdown from its own quanta. A quanta of 0 makes tx_allowed high in the next cycle.
- R5: While pause_en is low, pause_rx strobes leave tx_allowed unchanged.
- R6: A frame is in flight from a tx_start strobe until the next tx_done or collision strobe. While a frame is in flight, the pause countdown is frozen, so the frame in flight is never cut short. The full countdown runs only after the frame ends.
- R7: In normal mode, collision number n of a frame holds tx_allowed low for exactly r*SLOT_BITS bit_tick pulses. Here r is an integer from 0 to 2^min(n,BACKOFF_LIMIT)-1, taken from a free-running 16-bit LFSR.
- R8: With test_mode high, every backoff lasts exactly one slot (SLOT_BITS bit_tick pulses), whatever the attempt number.
- R9: Collision number MAX_ATTEMPTS (default 16) causes a one-cycle excess_retry pulse in the next cycle. It starts no backoff, and it resets the attempt count, so the following collision counts as number 1.
- R10: A tx_done strobe resets the attempt count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per bit time |
| rx_ce | input | 1 | Receive clock enable, used for the test-mode pause decrement |
| tx_start | input | 1 | Strobe: a frame transmission begins |
| tx_done | input | 1 | Strobe: the frame ended without a collision |
| collision | input | 1 | Strobe: the current attempt collided |
| pause_rx | input | 1 | Strobe: a valid pause request was received |
| pause_quanta | input | QUANTA_W | Pause length in quanta, valid with pause_rx |
| pause_en | input | 1 | Accept pause requests |
| test_mode | input | 1 | One-slot backoff and per-rx_ce pause decrement |
| tx_allowed | output | 1 | A new frame may start |
| excess_retry | output | 1 | One-cycle pulse: the frame was abandoned after too many attempts |

## Verification
The attempt count is hidden inside the block. A wrong count would show up as a backoff wait that exceeds the range allowed for the true attempt number. It could also move the excess_retry pulse to the wrong collision, or make the pulse appear after a tx_done should have cleared the count. Each of these shows at the ports within one collision sequence. A slot or quanta sub-counter that is off by one changes the measured hold-off by whole bit ticks. A pause countdown that keeps running during a frame in flight ends the hold-off too early. In both cases the error is visible the first time the timer expires.

// File: rtl/txdefer_pkg.sv
package txdefer_pkg;

    localparam int unsigned LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef struct packed {
        logic              load;
        logic [LFSR_W-1:0] slots;
    } backoff_req_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] nxt;
        nxt = s >> 1;
        if (s[0]) nxt = nxt ^ LFSR_TAPS;
        return nxt;
    endfunction

    function automatic logic [LFSR_W-1:0] backoff_mask(input int unsigned n,
                                                        input int unsigned limit);
        int unsigned e;
        e = (n < limit) ? n : limit;
        if (e >= LFSR_W) return '1;
        return (LFSR_W'(1) << e) - LFSR_W'(1);
    endfunction

endpackage

// File: rtl/txd_lfsr.sv
module txd_lfsr
    import txdefer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] value
);
    logic [LFSR_W-1:0] state;

    always_ff @(posedge clk) begin
        if (rst) state <= LFSR_SEED;
        else     state <= lfsr_step(state);
    end

    assign value = state;
endmodule

// File: rtl/txd_retry_unit.sv
module txd_retry_unit
    import txdefer_pkg::*;
#(
    parameter int unsigned MAX_ATTEMPTS  = 16,
    parameter int unsigned BACKOFF_LIMIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              collision,
    input  logic              tx_done,
    input  logic              test_mode,
    input  logic [LFSR_W-1:0] rnd,
    output backoff_req_t      req,
    output logic              excess
);
    localparam int unsigned AW = $clog2(MAX_ATTEMPTS + 1);

    logic [AW-1:0] attempts;
    logic [AW-1:0] next_n;
    logic          limit_hit;
    logic          excess_q;

    assign next_n    = attempts + AW'(1);
    assign limit_hit = (next_n == AW'(MAX_ATTEMPTS));

    always_ff @(posedge clk) begin
        if (rst) begin
            attempts <= '0;
            excess_q <= 1'b0;
        end else begin
            excess_q <= 1'b0;
            if (collision) begin
                if (limit_hit) begin
                    attempts <= '0;
                    excess_q <= 1'b1;
                end else begin
                    attempts <= next_n;
                end
            end else if (tx_done) begin
                attempts <= '0;
            end
        end
    end

    always_comb begin
        req.load  = collision && !limit_hit;
        if (test_mode)
            req.slots = LFSR_W'(1);
        else
            req.slots = rnd & backoff_mask(32'(next_n), BACKOFF_LIMIT);
    end

    assign excess = excess_q;
endmodule

// File: rtl/txd_unit_timer.sv
module txd_unit_timer #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned UNIT  = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             hold,
    input  logic             unit_tick,
    input  logic             fast_mode,
    input  logic             fast_tick,
    output logic             active
);
    localparam int unsigned SUB_W = (UNIT > 1) ? $clog2(UNIT) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UNIT - 1);

    logic [CNT_W-1:0] units_left;
    logic [SUB_W-1:0] sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            units_left <= '0;
            sub        <= '0;
        end else if (load) begin
            units_left <= load_val;
            sub        <= '0;
        end else if (units_left != '0 && !hold) begin
            if (fast_mode) begin
                if (fast_tick) units_left <= units_left - CNT_W'(1);
            end else if (unit_tick) begin
                if (sub == SUB_LAST) begin
                    sub        <= '0;
                    units_left <= units_left - CNT_W'(1);
                end else begin
                    sub <= sub + SUB_W'(1);
                end
            end
        end
    end

    assign active = (units_left != '0);
endmodule

// File: rtl/txdefer_ctrl.sv
module txdefer_ctrl
    import txdefer_pkg::*;
#(
    parameter int unsigned SLOT_BITS     = 512,
    parameter int unsigned QUANTUM_BITS  = 512,
    parameter int unsigned MAX_ATTEMPTS  = 16,
    parameter int unsigned BACKOFF_LIMIT = 10,
    parameter int unsigned QUANTA_W      = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_tick,
    input  logic                rx_ce,
    input  logic                tx_start,
    input  logic                tx_done,
    input  logic                collision,
    input  logic                pause_rx,
    input  logic [QUANTA_W-1:0] pause_quanta,
    input  logic                pause_en,
    input  logic                test_mode,
    output logic                tx_allowed,
    output logic                excess_retry
);
    logic [LFSR_W-1:0] rnd;
    backoff_req_t      bo_req;
    logic              bo_active;
    logic              pause_active;
    logic              in_flight;

    always_ff @(posedge clk) begin
        if (rst)                         in_flight <= 1'b0;
        else if (tx_done || collision)   in_flight <= 1'b0;
        else if (tx_start)               in_flight <= 1'b1;
    end

    txd_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .value (rnd)
    );

    txd_retry_unit #(
        .MAX_ATTEMPTS  (MAX_ATTEMPTS),
        .BACKOFF_LIMIT (BACKOFF_LIMIT)
    ) u_retry (
        .clk       (clk),
        .rst       (rst),
        .collision (collision),
        .tx_done   (tx_done),
        .test_mode (test_mode),
        .rnd       (rnd),
        .req       (bo_req),
        .excess    (excess_retry)
    );

    txd_unit_timer #(
        .CNT_W (LFSR_W),
        .UNIT  (SLOT_BITS)
    ) u_backoff (
        .clk       (clk),
        .rst       (rst),
        .load      (bo_req.load),
        .load_val  (bo_req.slots),
        .hold      (1'b0),
        .unit_tick (bit_tick),
        .fast_mode (1'b0),
        .fast_tick (1'b0),
        .active    (bo_active)
    );

    txd_unit_timer #(
        .CNT_W (QUANTA_W),
        .UNIT  (QUANTUM_BITS)
    ) u_pause (
        .clk       (clk),
        .rst       (rst),
        .load      (pause_rx && pause_en),
        .load_val  (pause_quanta),
        .hold      (in_flight),
        .unit_tick (bit_tick),
        .fast_mode (test_mode),
        .fast_tick (rx_ce),
        .active    (pause_active)
    );

    assign tx_allowed = !bo_active && !pause_active;
endmodule

// File: rtl/txdefer_chk.sv
module txdefer_chk #(
    parameter int unsigned QUANTA_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                collision,
    input logic                pause_rx,
    input logic [QUANTA_W-1:0] pause_quanta,
    input logic                pause_en,
    input logic                tx_allowed,
    input logic                excess_retry
);
    // R2
    pause_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        pause_en && pause_rx && pause_quanta != '0 |=> !tx_allowed);

    // R5
    allowed_holds_chk: assert property (@(posedge clk) disable iff (rst)
        tx_allowed && !collision && !(pause_en && pause_rx && pause_quanta != '0)
        |=> tx_allowed);

    // R9
    excess_single_chk: assert property (@(posedge clk) disable iff (rst)
        excess_retry |=> !excess_retry);

    // R9
    excess_cause_chk: assert property (@(posedge clk) disable iff (rst)
        excess_retry |-> $past(collision));
endmodule

bind txdefer_ctrl txdefer_chk #(.QUANTA_W(QUANTA_W)) u_txdefer_chk (
    .clk          (clk),
    .rst          (rst),
    .collision    (collision),
    .pause_rx     (pause_rx),
    .pause_quanta (pause_quanta),
    .pause_en     (pause_en),
    .tx_allowed   (tx_allowed),
    .excess_retry (excess_retry)
);

// File: tb/test_txdefer_ctrl.sv
module test_txdefer_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SB = 16;
    localparam int QB = 16;
    localparam int MAXA = 16;
    localparam int LIM = 10;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick = 0, rx_ce = 0, tx_start = 0, tx_done = 0, collision = 0;
    logic        pause_rx = 0, pause_en = 0, test_mode = 0;
    logic [15:0] pause_quanta = '0;
    logic        tx_allowed, excess_retry;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txdefer_ctrl #(
        .SLOT_BITS(SB), .QUANTUM_BITS(QB), .MAX_ATTEMPTS(MAXA),
        .BACKOFF_LIMIT(LIM), .QUANTA_W(16)
    ) i_txdefer_ctrl (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_ce(rx_ce),
        .tx_start(tx_start), .tx_done(tx_done), .collision(collision),
        .pause_rx(pause_rx), .pause_quanta(pause_quanta), .pause_en(pause_en),
        .test_mode(test_mode), .tx_allowed(tx_allowed), .excess_retry(excess_retry)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            failures++;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int exp_pause(input int q, input bit tm);
        return tm ? q : q * QB;
    endfunction

    function automatic int exp_bo_max(input int n);
        int e;
        e = (n < LIM) ? n : LIM;
        return ((1 << e) - 1) * SB;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        tx_start = 1; step(); tx_start = 0;
    endtask

    task automatic pulse_done();
        tx_done = 1; step(); tx_done = 0;
    endtask

    task automatic pulse_pause(input int q);
        pause_rx = 1; pause_quanta = 16'(q); step(); pause_rx = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1; step(); bit_tick = 0;
        end
    endtask

    // counts bit_tick (or rx_ce) pulses applied until tx_allowed is high
    task automatic measure(input bit use_ce, output int t);
        t = 0;
        while (!tx_allowed && t < 20000) begin
            if (use_ce) rx_ce = 1; else bit_tick = 1;
            step();
            rx_ce = 0; bit_tick = 0;
            t++;
        end
    endtask

    // one attempt ending in collision; returns the excess flag after it
    task automatic collide(output bit exc);
        pulse_start();
        collision = 1; step(); collision = 0;
        exc = excess_retry;
    endtask

    initial begin
        int t, q;
        bit exc, tm;
        int nonzero;
        void'($urandom(32'd20240611));
        repeat (3) step();
        rst = 0;
        step();

        // R1 reset state
        check(tx_allowed === 1'b1, "R1 tx_allowed", int'(tx_allowed), 1);
        check(excess_retry === 1'b0, "R1 excess_retry", int'(excess_retry), 0);

        // R2 normal pause
        pause_en = 1;
        pulse_pause(3);
        check(tx_allowed === 1'b0, "R2 held", int'(tx_allowed), 0);
        measure(0, t);
        check(t == exp_pause(3, 0), "R2 release", t, exp_pause(3, 0));

        // R3 test-mode pause, bit ticks ignored
        test_mode = 1;
        pulse_pause(4);
        ticks(40);
        check(tx_allowed === 1'b0, "R3 bit_tick ignored", int'(tx_allowed), 0);
        measure(1, t);
        check(t == exp_pause(4, 1), "R3 release", t, exp_pause(4, 1));
        test_mode = 0;

        // R4 reload and zero quanta
        pulse_pause(5);
        ticks(QB * 2 + 3);
        pulse_pause(3);
        measure(0, t);
        check(t == exp_pause(3, 0), "R4 reload", t, exp_pause(3, 0));
        pulse_pause(4);
        ticks(5);
        pulse_pause(0);
        check(tx_allowed === 1'b1, "R4 zero quanta", int'(tx_allowed), 1);

        // R5 pause disabled
        pause_en = 0;
        pulse_pause(6);
        check(tx_allowed === 1'b1, "R5 ignored", int'(tx_allowed), 1);
        ticks(10);
        check(tx_allowed === 1'b1, "R5 still allowed", int'(tx_allowed), 1);
        pause_en = 1;

        // R6 pause during a frame in flight
        pulse_start();
        pulse_pause(2);
        ticks(QB + 5);
        check(tx_allowed === 1'b0, "R6 held during frame", int'(tx_allowed), 0);
        pulse_done();
        measure(0, t);
        check(t == exp_pause(2, 0), "R6 full count after frame", t, exp_pause(2, 0));

        // R3 R2 random pauses
        for (int k = 0; k < 20; k++) begin
            q = $urandom_range(0, 9);
            tm = 1'($urandom_range(0, 1));
            test_mode = tm;
            pulse_pause(q);
            measure(tm, t);
            check(t == exp_pause(q, tm), tm ? "R3 random" : "R2 random", t, exp_pause(q, tm));
        end
        test_mode = 0;

        // R8 one-slot backoff, R10 done resets count, R9 excess
        test_mode = 1;
        for (int n = 1; n < MAXA; n++) begin
            collide(exc);
            check(exc === 1'b0, "R10 no excess first run", int'(exc), 0);
            measure(0, t);
            check(t == SB, "R8 one slot", t, SB);
        end
        pulse_start();
        pulse_done();
        for (int n = 1; n < MAXA; n++) begin
            collide(exc);
            check(exc === 1'b0, "R10 count cleared by done", int'(exc), 0);
            measure(0, t);
        end
        collide(exc);
        check(exc === 1'b1, "R9 excess pulse", int'(exc), 1);
        check(tx_allowed === 1'b1, "R9 no backoff", int'(tx_allowed), 1);
        step();
        check(excess_retry === 1'b0, "R9 single cycle", int'(excess_retry), 0);
        test_mode = 0;

        // R9 count restarts: next collision is number 1
        collide(exc);
        measure(0, t);
        check(t <= exp_bo_max(1) && t % SB == 0, "R9 restart range", t, exp_bo_max(1));
        pulse_start();
        pulse_done();

        // R7 random backoff ranges
        nonzero = 0;
        for (int rep = 0; rep < 4; rep++) begin
            for (int n = 1; n <= 6; n++) begin
                collide(exc);
                measure(0, t);
                if (t != 0) nonzero++;
                check(t % SB == 0 && t <= exp_bo_max(n), "R7 backoff range", t, exp_bo_max(n));
            end
            pulse_start();
            pulse_done();
        end
        check(nonzero > 0, "R7 random waits nonzero", nonzero, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule